// File: doc/BRIEF.md
# Set-Associative Read Cache Controller

This block is a small read-only cache placed between a processor-side request port and a memory-side fetch port. Requests carry a word address and a flag that marks them as instruction or data fetches. When the cache is enabled, each request is looked up in a four-way set-associative tag store. A hit returns the stored word one cycle later with no memory traffic. A miss fetches the whole line, word by word, through the memory port. It places the line in the way that the set's replacement pointer names, then returns the requested word.

A small control interface gives software the means to keep the cache consistent with memory. It has an enable bit and a status bit that reports the mode in effect. There is a line invalidate command, addressed by set index and way, and an invalidate-all strobe. The intended line maintenance sequence has four steps. First clear the enable bit. Then wait for the status bit to report the cache disabled. Then invalidate the chosen line. Finally set the enable bit again. While the cache is disabled, every request passes straight to the memory port with no lookup and no fill. Each hit raises a one-cycle pulse, split by request type, so that an external event counter can measure hit rates.

Top module: `rcache_top`

## Requirements
- R1: After reset the cache is enabled (`sts_disabled` = 0), the outputs `s_ack`, `m_req`, `hit_instr` and `hit_data` are 0, and every line is invalid, so the first request to any address misses.
- R2: With the cache enabled, a request that hits is answered with `s_ack` high for exactly one cycle. This comes on the first clock edge after the request is presented. `s_rdata` carries the word held in the line, even if memory has changed since the line was filled. No memory transfer takes place.
- R3: The address is a word address. Bits [1:0] select the word in the line, bits [5:2] select the set and bits [15:6] form the tag. A miss fetches all 4 words of the line through the memory port, with offsets 0, 1, 2, 3 in that order. It then returns the requested word with a one-cycle `s_ack`, and the line hits afterwards.
- R4: Each set has a replacement pointer that starts at way 0 after reset. A fill goes into the way the pointer names, and the pointer then advances to the next way, wrapping from way 3 to way 0.
- R5: A one-cycle `inv_line_stb` clears the valid bit of the single line named by `inv_index` and `inv_way`, and all other lines keep their contents. It also sets that set's replacement pointer to `inv_way`, so the next fill in that set uses it.
- R6: A one-cycle `inv_all_stb` clears every valid bit. A lookup made in the same cycle as the strobe reports a miss.
- R7: While `sts_disabled` is 1, `m_req`, `m_addr`, `s_ack` and `s_rdata` are forwarded between the two ports unchanged. Exactly one memory transfer serves each request, no hit pulse is raised, and the cache contents are left untouched.
- R8: `sts_disabled` takes the inverse of the enable bit written through `cfg_en_wr`/`cfg_en_val` only while no fill is in progress and no request is pending. It never changes during a line fill.
- R9: A hit raises `hit_instr` if `s_is_instr` was 1 for that request, and `hit_data` otherwise. The pulse lasts one cycle, coincides with `s_ack`, and is never raised for misses or forwarded requests.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_req | input | 1 | Processor request, held until `s_ack` |
| s_addr | input | 16 | Processor word address |
| s_is_instr | input | 1 | 1 = instruction fetch, 0 = data read |
| s_ack | output | 1 | One-cycle completion of a processor request |
| s_rdata | output | 32 | Read data, valid with `s_ack` |
| m_req | output | 1 | Memory request, held until `m_ack` |
| m_addr | output | 16 | Memory word address |
| m_ack | input | 1 | One-cycle memory completion |
| m_rdata | input | 32 | Memory data, valid with `m_ack` |
| cfg_en_wr | input | 1 | Write strobe for the enable bit |
| cfg_en_val | input | 1 | Enable value written by `cfg_en_wr` |
| sts_disabled | output | 1 | 1 when the cache is in forwarding mode |
| inv_line_stb | input | 1 | Invalidate one line |
| inv_index | input | 4 | Set index of the line to invalidate |
| inv_way | input | 2 | Way of the line to invalidate |
| inv_all_stb | input | 1 | Invalidate every line |
| hit_instr | output | 1 | One-cycle pulse on an instruction hit |
| hit_data | output | 1 | One-cycle pulse on a data hit |

## Verification
On every cycle, the checker covers the following behaviours:
- hit pulses come only with an acknowledge and only in cached mode, and each names the type of the request that caused it;
- a cached-mode acknowledge lasts a single cycle, and none is given while a fill is on the memory port;
- in forwarding mode the request and acknowledge pass straight through;
- the status bit never flips while a fill is outstanding;
- a lookup that meets an invalidate-all strobe yields no hit.

Other behaviours can be shown only by the bench's scenarios, which compare returned data, memory transfer counts and fill order against a behavioural model:
- which way a fill replaces, under round-robin and after a line invalidate;
- that stale data is served until an invalidate;
- that a line invalidate leaves the other lines of its set in place;
- that forwarded reads leave the cached contents intact.

// File: rtl/rcache_pkg.sv
package rcache_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } rc_state_t;
endpackage

// File: rtl/rcache_tags.sv
module rcache_tags #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int TAGW = 10,
  localparam int IDXW  = $clog2(SETS),
  localparam int WAYW  = $clog2(WAYS),
  localparam int LINES = SETS * WAYS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [IDXW-1:0] lk_idx,
  input  logic [TAGW-1:0] lk_tag,
  output logic            lk_hit,
  output logic [WAYW-1:0] lk_way,
  output logic [WAYW-1:0] lk_victim,
  input  logic            fill_we,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [WAYW-1:0] fill_way,
  input  logic [TAGW-1:0] fill_tag,
  input  logic            inv_line,
  input  logic [IDXW-1:0] inv_idx,
  input  logic [WAYW-1:0] inv_way,
  input  logic            inv_all
);
  logic [LINES-1:0] valid_q;
  logic [TAGW-1:0]  tag_mem [LINES];
  logic [WAYW-1:0]  rr_q    [SETS];
  logic [WAYS-1:0]  match;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = valid_q[{lk_idx, WAYW'(w)}] &&
                      (tag_mem[{lk_idx, WAYW'(w)}] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (match[w]) lk_way = WAYW'(w);
    end
  end

  assign lk_hit    = |match;
  assign lk_victim = rr_q[lk_idx];

  // Tag storage carries no reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (fill_we) tag_mem[{fill_idx, fill_way}] <= fill_tag;
  end

  // Later statements win: line invalidate overrides fill, invalidate-all overrides both.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else begin
      if (fill_we) begin
        valid_q[{fill_idx, fill_way}] <= 1'b1;
        rr_q[fill_idx]                <= fill_way + 1'b1;
      end
      if (inv_line) begin
        valid_q[{inv_idx, inv_way}] <= 1'b0;
        rr_q[inv_idx]               <= inv_way;
      end
      if (inv_all) valid_q <= '0;
    end
  end
endmodule

// File: rtl/rcache_data.sv
module rcache_data #(
  parameter int DW  = 32,
  parameter int RAW = 8,
  localparam int DEPTH = 1 << RAW
) (
  input  logic           clk,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic           re,
  input  logic [RAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rcache_top.sv
module rcache_top
  import rcache_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int AW    = 16,
  localparam int OFFW = $clog2(WORDS),
  localparam int IDXW = $clog2(SETS),
  localparam int WAYW = $clog2(WAYS),
  localparam int TAGW = AW - IDXW - OFFW,
  localparam int RAW  = IDXW + WAYW + OFFW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            s_req,
  input  logic [AW-1:0]   s_addr,
  input  logic            s_is_instr,
  output logic            s_ack,
  output logic [DW-1:0]   s_rdata,
  output logic            m_req,
  output logic [AW-1:0]   m_addr,
  input  logic            m_ack,
  input  logic [DW-1:0]   m_rdata,
  input  logic            cfg_en_wr,
  input  logic            cfg_en_val,
  output logic            sts_disabled,
  input  logic            inv_line_stb,
  input  logic [IDXW-1:0] inv_index,
  input  logic [WAYW-1:0] inv_way,
  input  logic            inv_all_stb,
  output logic            hit_instr,
  output logic            hit_data
);
  localparam logic [OFFW-1:0] LAST_OFF = OFFW'(WORDS - 1);

  rc_state_t       state_q;
  logic            en_q, dis_q;
  logic [AW-1:0]   req_addr_q;
  logic [WAYW-1:0] victim_q;
  logic [OFFW-1:0] cnt_q;
  logic [DW-1:0]   fill_word_q;
  logic            from_ram_q, ack_q, hit_i_q, hit_d_q, freq_q;

  logic [TAGW-1:0] lk_tag;
  logic [IDXW-1:0] lk_idx, req_idx;
  logic [OFFW-1:0] lk_off, req_off;
  logic            tag_hit, hit_ok, lookup_go, beat, fill_done;
  logic [WAYW-1:0] hit_way, rr_way;
  logic [DW-1:0]   ram_q;

  assign lk_tag  = s_addr[AW-1 -: TAGW];
  assign lk_idx  = s_addr[OFFW +: IDXW];
  assign lk_off  = s_addr[OFFW-1:0];
  assign req_idx = req_addr_q[OFFW +: IDXW];
  assign req_off = req_addr_q[OFFW-1:0];

  assign lookup_go = !dis_q && (state_q == ST_IDLE) && s_req && !ack_q;
  assign hit_ok    = tag_hit && !inv_all_stb;
  assign beat      = (state_q == ST_FILL) && m_ack;
  assign fill_done = beat && (cnt_q == LAST_OFF);

  rcache_tags #(.WAYS(WAYS), .SETS(SETS), .TAGW(TAGW)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .lk_idx   (lk_idx),
    .lk_tag   (lk_tag),
    .lk_hit   (tag_hit),
    .lk_way   (hit_way),
    .lk_victim(rr_way),
    .fill_we  (fill_done),
    .fill_idx (req_idx),
    .fill_way (victim_q),
    .fill_tag (req_addr_q[AW-1 -: TAGW]),
    .inv_line (inv_line_stb),
    .inv_idx  (inv_index),
    .inv_way  (inv_way),
    .inv_all  (inv_all_stb)
  );

  rcache_data #(.DW(DW), .RAW(RAW)) u_data (
    .clk  (clk),
    .we   (beat),
    .waddr({req_idx, victim_q, cnt_q}),
    .wdata(m_rdata),
    .re   (lookup_go && hit_ok),
    .raddr({lk_idx, hit_way, lk_off}),
    .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      en_q        <= 1'b1;
      dis_q       <= 1'b0;
      req_addr_q  <= '0;
      victim_q    <= '0;
      cnt_q       <= '0;
      fill_word_q <= '0;
      from_ram_q  <= 1'b0;
      ack_q       <= 1'b0;
      hit_i_q     <= 1'b0;
      hit_d_q     <= 1'b0;
      freq_q      <= 1'b0;
    end else begin
      ack_q   <= 1'b0;
      hit_i_q <= 1'b0;
      hit_d_q <= 1'b0;
      if (cfg_en_wr) en_q <= cfg_en_val;
      case (state_q)
        ST_IDLE: begin
          if (!s_req) begin
            dis_q <= !en_q;
          end else if (lookup_go) begin
            if (hit_ok) begin
              ack_q      <= 1'b1;
              from_ram_q <= 1'b1;
              hit_i_q    <= s_is_instr;
              hit_d_q    <= !s_is_instr;
            end else begin
              state_q    <= ST_FILL;
              req_addr_q <= s_addr;
              victim_q   <= rr_way;
              cnt_q      <= '0;
              freq_q     <= 1'b1;
            end
          end
        end
        ST_FILL: begin
          if (m_ack) begin
            if (cnt_q == req_off) fill_word_q <= m_rdata;
            cnt_q <= cnt_q + 1'b1;
            if (fill_done) begin
              freq_q     <= 1'b0;
              state_q    <= ST_IDLE;
              ack_q      <= 1'b1;
              from_ram_q <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign s_ack        = dis_q ? m_ack   : ack_q;
  assign s_rdata      = dis_q ? m_rdata : (from_ram_q ? ram_q : fill_word_q);
  assign m_req        = dis_q ? s_req   : freq_q;
  assign m_addr       = dis_q ? s_addr  : {req_addr_q[AW-1:OFFW], cnt_q};
  assign sts_disabled = dis_q;
  assign hit_instr    = hit_i_q;
  assign hit_data     = hit_d_q;
endmodule

// File: rtl/rcache_chk.sv
module rcache_chk (
  input logic clk,
  input logic rst,
  input logic s_req,
  input logic s_is_instr,
  input logic s_ack,
  input logic m_req,
  input logic m_ack,
  input logic sts_disabled,
  input logic inv_all_stb,
  input logic hit_instr,
  input logic hit_data
);
  assert_reset_enabled_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sts_disabled && !s_ack && !hit_instr && !hit_data);

  assert_ack_single_R2: assert property (@(posedge clk) disable iff (rst)
    (s_ack && !sts_disabled) |=> !s_ack);

  assert_no_ack_in_fill_R3: assert property (@(posedge clk) disable iff (rst)
    (m_req && !sts_disabled) |-> !s_ack);

  assert_invall_miss_R6: assert property (@(posedge clk) disable iff (rst)
    (s_req && !s_ack && !sts_disabled && inv_all_stb) |=> !(hit_instr || hit_data));

  assert_bypass_fwd_R7: assert property (@(posedge clk) disable iff (rst)
    sts_disabled |-> (m_req == s_req) && (s_ack == m_ack) && !hit_instr && !hit_data);

  assert_status_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (m_req && !sts_disabled) |=> !sts_disabled);

  assert_hit_with_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_instr || hit_data) |-> s_ack && !sts_disabled && !(hit_instr && hit_data));

  assert_hit_kind_R9: assert property (@(posedge clk) disable iff (rst)
    (hit_instr || hit_data) |-> (hit_instr == $past(s_is_instr)));
endmodule

bind rcache_top rcache_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_req       (s_req),
  .s_is_instr  (s_is_instr),
  .s_ack       (s_ack),
  .m_req       (m_req),
  .m_ack       (m_ack),
  .sts_disabled(sts_disabled),
  .inv_all_stb (inv_all_stb),
  .hit_instr   (hit_instr),
  .hit_data    (hit_data)
);

// File: tb/tb_rcache_top.sv
module tb_rcache_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        s_req = 1'b0, s_is_instr = 1'b0;
  logic [15:0] s_addr = '0;
  logic        s_ack, m_req, m_ack, sts_disabled, hit_instr, hit_data;
  logic [31:0] s_rdata, m_rdata;
  logic [15:0] m_addr;
  logic        cfg_en_wr = 1'b0, cfg_en_val = 1'b1;
  logic        inv_line_stb = 1'b0, inv_all_stb = 1'b0;
  logic [3:0]  inv_index = '0;
  logic [1:0]  inv_way = '0;

  int nvec = 0, nbad = 0;
  int gen = 1;
  bit finished = 0;

  // behavioural model state
  bit          mvalid [16][4];
  logic [9:0]  mtag   [16][4];
  logic [31:0] mdata  [16][4][4];
  int          mrr    [16];
  bit          mdis = 0;

  always #10 clk = ~clk;

  rcache_top dut (
    .clk(clk), .rst(rst), .s_req(s_req), .s_addr(s_addr), .s_is_instr(s_is_instr),
    .s_ack(s_ack), .s_rdata(s_rdata), .m_req(m_req), .m_addr(m_addr),
    .m_ack(m_ack), .m_rdata(m_rdata), .cfg_en_wr(cfg_en_wr), .cfg_en_val(cfg_en_val),
    .sts_disabled(sts_disabled), .inv_line_stb(inv_line_stb), .inv_index(inv_index),
    .inv_way(inv_way), .inv_all_stb(inv_all_stb), .hit_instr(hit_instr), .hit_data(hit_data)
  );

  function automatic logic [31:0] memf(int g, logic [15:0] a);
    return {g[7:0], 8'hC3, a};
  endfunction

  function automatic logic [15:0] mk(int tg, int idx, int off);
    return {tg[9:0], idx[3:0], off[1:0]};
  endfunction

  // memory: one-cycle acknowledge, every other cycle while requested
  always @(posedge clk) begin
    if (rst) m_ack <= 1'b0;
    else begin
      m_ack   <= m_req && !m_ack;
      m_rdata <= memf(gen, m_addr);
    end
  end

  task automatic chk(bit ok, string rq, string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic do_read(logic [15:0] a, bit instr, bit inv_now, int dis_at, string rq);
    int idx, off, hw, v, cyc, nacks;
    logic [9:0] tg;
    logic [31:0] exp_d;
    bit exp_hit;
    int exp_acks;
    idx = a[5:2]; off = a[1:0]; tg = a[15:6];
    exp_hit = 0;
    if (!mdis) begin
      if (inv_now) for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) mvalid[s][w] = 0;
      hw = -1;
      for (int w = 0; w < 4; w++) if (mvalid[idx][w] && mtag[idx][w] == tg) hw = w;
      if (hw >= 0) begin
        exp_hit = 1; exp_d = mdata[idx][hw][off]; exp_acks = 0;
      end else begin
        v = mrr[idx];
        for (int o = 0; o < 4; o++) mdata[idx][v][o] = memf(gen, {a[15:2], o[1:0]});
        mvalid[idx][v] = 1; mtag[idx][v] = tg; mrr[idx] = (v + 1) % 4;
        exp_d = memf(gen, a); exp_acks = 4;
      end
    end else begin
      exp_d = memf(gen, a); exp_acks = 1;
    end
    s_req = 1; s_addr = a; s_is_instr = instr; inv_all_stb = inv_now;
    cyc = 0; nacks = 0;
    while (cyc < 200) begin
      @(negedge clk);
      inv_all_stb = 0;
      cfg_en_wr = 0;
      cyc++;
      if (cyc == dis_at) begin cfg_en_wr = 1; cfg_en_val = 0; end
      if (m_ack) begin
        if (!mdis) chk(m_addr[1:0] == nacks[1:0], "R3", "fill word order",
                       {30'd0, m_addr[1:0]}, nacks);
        nacks++;
      end
      if (dis_at > 0) chk(!sts_disabled, "R8", "status held during fill", sts_disabled, 0);
      if (s_ack) break;
      chk(!hit_instr && !hit_data, "R9", "no hit pulse before ack", {hit_instr, hit_data}, 0);
    end
    s_req = 0;
    chk(s_ack, rq, "ack seen", s_ack, 1);
    chk(s_rdata === exp_d, rq, "read data", s_rdata, exp_d);
    chk(nacks == exp_acks, rq, "memory transfers", nacks, exp_acks);
    chk(hit_instr == (exp_hit && instr) && hit_data == (exp_hit && !instr), "R9",
        "hit pulse kind", {hit_instr, hit_data}, {exp_hit && instr, exp_hit && !instr});
    if (exp_hit) chk(cyc == 1, "R2", "hit latency", cyc, 1);
    @(negedge clk);
    chk(!hit_instr && !hit_data, "R9", "hit pulse one cycle", {hit_instr, hit_data}, 0);
  endtask

  task automatic wait_sts(bit want, string rq);
    int n;
    n = 0;
    while (sts_disabled !== want && n < 10) begin @(negedge clk); n++; end
    chk(sts_disabled === want, rq, "status bit", sts_disabled, want);
    mdis = want;
  endtask

  task automatic set_en(bit v);
    cfg_en_wr = 1; cfg_en_val = v;
    @(negedge clk);
    cfg_en_wr = 0;
    wait_sts(!v, "R8");
  endtask

  task automatic do_inv_line(int idx, int way);
    inv_line_stb = 1; inv_index = idx[3:0]; inv_way = way[1:0];
    @(negedge clk);
    inv_line_stb = 0;
    mvalid[idx][way] = 0; mrr[idx] = way;
  endtask

  task automatic do_inv_all();
    inv_all_stb = 1;
    @(negedge clk);
    inv_all_stb = 0;
    for (int s = 0; s < 16; s++) for (int w = 0; w < 4; w++) mvalid[s][w] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      mrr[s] = 0;
      for (int w = 0; w < 4; w++) mvalid[s][w] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(!sts_disabled && !s_ack && !m_req && !hit_instr && !hit_data, "R1", "reset outputs",
        {sts_disabled, s_ack, m_req, hit_instr, hit_data}, 0);

    // R1/R3 first access misses, then R2 hits within the line
    do_read(mk(9, 3, 2), 1, 0, 0, "R1");
    do_read(mk(9, 3, 2), 1, 0, 0, "R2");
    do_read(mk(9, 3, 0), 0, 0, 0, "R2");
    do_read(mk(9, 3, 3), 0, 0, 0, "R3");
    // R2 stale data served from storage after memory changes
    gen = 2;
    do_read(mk(9, 3, 1), 1, 0, 0, "R2");

    // R4 round-robin in set 5
    for (int t = 1; t <= 4; t++) do_read(mk(t, 5, t % 4), 0, 0, 0, "R4");
    do_read(mk(5, 5, 0), 0, 0, 0, "R4");  // evicts tag 1 (way 0)
    do_read(mk(1, 5, 1), 1, 0, 0, "R4");  // miss, evicts tag 2 (way 1)
    do_read(mk(3, 5, 2), 0, 0, 0, "R4");  // still cached

    // R5 line invalidate procedure on set 5 way 2 (tag 3)
    set_en(0);
    do_inv_line(5, 2);
    set_en(1);
    do_read(mk(4, 5, 3), 1, 0, 0, "R5");  // way 3 untouched: hit
    do_read(mk(3, 5, 2), 0, 0, 0, "R5");  // invalidated: miss, refill into way 2
    do_read(mk(7, 5, 0), 0, 0, 0, "R5");  // next fill in way 3
    do_read(mk(4, 5, 1), 0, 0, 0, "R5");  // tag 4 evicted: miss

    // R7 forwarding leaves cache intact
    set_en(0);
    gen = 3;
    do_read(mk(9, 3, 1), 1, 0, 0, "R7");
    do_read(mk(12, 8, 2), 0, 0, 0, "R7");
    set_en(1);
    do_read(mk(9, 3, 1), 1, 0, 0, "R7");  // old contents, still a hit
    do_read(mk(12, 8, 2), 0, 0, 0, "R7"); // never filled while forwarding: miss

    // R8 disable requested mid-fill
    do_read(mk(20, 10, 1), 0, 0, 2, "R8");
    wait_sts(1, "R8");
    set_en(1);

    // R6 invalidate all, then same-cycle lookup
    do_inv_all();
    do_read(mk(9, 3, 1), 1, 0, 0, "R6");
    do_read(mk(9, 3, 1), 1, 0, 0, "R6");
    do_read(mk(9, 3, 1), 0, 1, 0, "R6");
    do_read(mk(9, 3, 0), 0, 0, 0, "R6");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule